// File: doc/BRIEF.md
# MSI to Adapter Interrupt Converter

This block turns 32-bit message-signalled interrupt data writes into adapter-interrupt indicator updates. Each write carries a function id in its upper bits and a vector number in its low bits. The block looks the id up in a small table of function entries. The matching entry gives an indicator-word index, a summary-bit offset and an interrupt subclass. The block then sets the vector's bit in one of several local 64-bit indicator words and test-and-sets the function's bit in a 64-bit summary word.

An I/O interrupt request is raised only when that summary bit was clear before the write. Later vectors from functions that share an already-set summary bit are therefore merged into the pending interrupt. Both indicator words number their bits from the most significant end. Software clears indicator and summary bits through a mask port, which lets later writes raise a fresh interrupt. A read of the write window returns all ones.

Top module: `msi_ai_conv`

## Requirements
- R1: The write data `wr_data` is taken as a little-endian 32-bit value. The function id is `wr_data[31:11]`, zero-extended to 32 bits and compared with the stored 32-bit id. The vector is `wr_data[6:0]`. Bits 10:7 have no effect.
- R2: A write whose id matches no valid table entry is dropped. No indicator bit changes, no summary bit changes, and no interrupt pulse occurs.
- R3: For a matching write, one cycle later the indicator word with index (entry index field + vector bit 6) modulo NUM_IND has bit (63 − vector[5:0]) set. Other bits keep their values.
- R4: For a matching write, one cycle later the summary word has bit (63 − entry summary offset) set.
- R5: `irq_valid` is high for exactly the cycle after a matching write, and only if the summary bit from R4 was clear before the write. In that cycle `irq_word` = (subclass << 27) | (1 << 31). Otherwise `irq_valid` stays low.
- R6: `rd_data` is 0xFFFFFFFF while `rd_en` is high and 0 otherwise.
- R7: When several valid entries hold the same id, the entry with the lowest table index is used.
- R8: With `clr_en` high, the bits set in `clr_vec_mask` are cleared in indicator word `clr_sel`, and the bits set in `clr_sum_mask` are cleared in the summary word, one cycle later. A later write to a cleared summary bit raises a new interrupt. If a bit is set and cleared in the same cycle, the set wins.
- R9: After a synchronous active-low reset, all indicator and summary words are zero, every table entry is invalid, and `irq_valid` is low.
- R10: With `cfg_we` high, table entry `cfg_idx` is loaded with the valid bit, id, subclass, summary offset and index fields. The new entry takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | MSI data write strobe |
| wr_data | input | 32 | MSI data word |
| rd_en | input | 1 | Read of the write window |
| rd_data | output | 32 | Read data, all ones during a read |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 3 | Table entry number |
| cfg_vld | input | 1 | Entry valid bit |
| cfg_fid | input | 32 | Entry function id |
| cfg_isc | input | 3 | Entry interrupt subclass |
| cfg_soff | input | 6 | Entry summary bit offset |
| cfg_ind | input | 2 | Entry indicator-word index |
| clr_en | input | 1 | Clear strobe |
| clr_sel | input | 2 | Indicator word to clear |
| clr_vec_mask | input | 64 | Indicator bits to clear |
| clr_sum_mask | input | 64 | Summary bits to clear |
| ind_sel | input | 2 | Indicator word to observe |
| ind_word | output | 64 | Selected indicator word |
| sum_word | output | 64 | Summary word |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_word | output | 32 | Interruption word |

## Verification
The assertions assume that `wr_valid` is low throughout reset. The summary and indicator assertions also assume that no clear aimed at the same bits coincides with a write. In the bench, every stimulus task drives writes and clears in separate cycles and holds all strobes low while reset is applied. Table writes happen only while no MSI write is in flight, so each lookup sees a settled table.

// File: rtl/msi_ai_pkg.sv
// Package: shared sizes and the function-table entry type for the
// MSI to adapter interrupt converter. Assumes NUM_IND is a power of two.
package msi_ai_pkg;
    localparam int NUM_FN   = 8;
    localparam int NUM_IND  = 4;
    localparam int FN_W     = $clog2(NUM_FN);
    localparam int IND_W    = $clog2(NUM_IND);
    localparam int WORD_W   = 64;
    localparam int POS_W    = $clog2(WORD_W);
    localparam int ISC_W    = 3;
    localparam int ID_W     = 32;
    localparam int VEC_W    = 7;
    localparam int ID_SHIFT = 11;
    localparam int ISC_SHIFT = 27;

    typedef struct packed {
        logic             vld;
        logic [ID_W-1:0]  fid;
        logic [ISC_W-1:0] isc;
        logic [POS_W-1:0] soff;
        logic [IND_W-1:0] ind;
    } fn_entry_t;
endpackage

// File: rtl/msi_ai_ftab.sv
// Function table: NUM_FN registered entries, loaded through a write port,
// and a combinational id lookup. The lowest matching index wins.
// Assumes the lookup id is already zero-extended to ID_W bits.
module msi_ai_ftab
    import msi_ai_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [FN_W-1:0] cfg_idx,
    input  fn_entry_t       cfg_entry,
    input  logic [ID_W-1:0] lk_fid,
    output logic            lk_hit,
    output fn_entry_t       lk_entry
);
    fn_entry_t         tbl [NUM_FN];
    logic [NUM_FN-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_FN; g++) begin : g_ent
            // Load or reset one table entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tbl[g] <= '0;
                else if (cfg_we && cfg_idx == FN_W'(g))
                    tbl[g] <= cfg_entry;
            end
            // Compare this entry against the looked-up id.
            assign match[g] = tbl[g].vld && (tbl[g].fid == lk_fid);
        end
    endgenerate

    // Priority select: scan downward so the lowest index ends up chosen.
    always_comb begin
        lk_entry = '0;
        for (int i = NUM_FN - 1; i >= 0; i--)
            if (match[i])
                lk_entry = tbl[i];
    end

    assign lk_hit = |match;
endmodule

// File: rtl/msi_ai_ind.sv
// Indicator bank: NUM_IND vector indicator words and one summary word.
// Set requests win over clear masks in the same cycle. sum_was reports the
// stored (pre-write) value of the requested summary bit.
// Assumes set positions are already converted to LSB-based bit numbers.
module msi_ai_ind
    import msi_ai_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IND_W-1:0]  set_widx,
    input  logic [POS_W-1:0]  set_vpos,
    input  logic [POS_W-1:0]  set_spos,
    input  logic              clr_en,
    input  logic [IND_W-1:0]  clr_sel,
    input  logic [WORD_W-1:0] clr_vec_mask,
    input  logic [WORD_W-1:0] clr_sum_mask,
    input  logic [IND_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] sum_q,
    output logic              sum_was
);
    logic [WORD_W-1:0] vec_q [NUM_IND];
    logic [WORD_W-1:0] sum_set, sum_clr;

    genvar g;
    generate
        for (g = 0; g < NUM_IND; g++) begin : g_word
            logic [WORD_W-1:0] set_m, clr_m;
            // Per-word set and clear masks.
            assign set_m = (set_en && set_widx == IND_W'(g)) ?
                           (WORD_W'(1) << set_vpos) : '0;
            assign clr_m = (clr_en && clr_sel == IND_W'(g)) ? clr_vec_mask : '0;
            // Update one indicator word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    vec_q[g] <= '0;
                else
                    vec_q[g] <= (vec_q[g] & ~clr_m) | set_m;
            end
        end
    endgenerate

    assign sum_set = set_en ? (WORD_W'(1) << set_spos) : '0;
    assign sum_clr = clr_en ? clr_sum_mask : '0;

    // Update the summary word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= (sum_q & ~sum_clr) | sum_set;
    end

    assign sum_was = sum_q[set_spos];
    assign rd_word = vec_q[rd_sel];

    assert_vec_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> vec_q[$past(set_widx)][$past(set_vpos)]);

    assert_sum_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> sum_q[$past(set_spos)]);
endmodule

// File: rtl/msi_ai_irq.sv
// Interrupt pulser: registers a one-cycle request carrying the
// interruption word built from the subclass and the adapter flag (bit 31).
// Assumes fire is high for at most one cycle per accepted write.
module msi_ai_irq
    import msi_ai_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [ISC_W-1:0] isc,
    output logic             irq_valid,
    output logic [31:0]      irq_word
);
    // Capture a request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_word  <= '0;
        end else begin
            irq_valid <= fire;
            irq_word  <= fire ? ((32'(isc) << ISC_SHIFT) | 32'h8000_0000) : '0;
        end
    end
endmodule

// File: rtl/msi_ai_conv.sv
// MSI to adapter interrupt converter top. It decodes the id and vector from
// the MSI data, looks up the function, updates the indicator bank with
// MSB-first bit numbering, and pulses an interrupt when the summary bit was
// clear. Assumes wr_valid is low during reset.
module msi_ai_conv
    import msi_ai_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_idx,
    input  logic        cfg_vld,
    input  logic [31:0] cfg_fid,
    input  logic [2:0]  cfg_isc,
    input  logic [5:0]  cfg_soff,
    input  logic [1:0]  cfg_ind,
    input  logic        clr_en,
    input  logic [1:0]  clr_sel,
    input  logic [63:0] clr_vec_mask,
    input  logic [63:0] clr_sum_mask,
    input  logic [1:0]  ind_sel,
    output logic [63:0] ind_word,
    output logic [63:0] sum_word,
    output logic        irq_valid,
    output logic [31:0] irq_word
);
    fn_entry_t        cfg_entry, lk_entry;
    logic [ID_W-1:0]  lk_fid;
    logic [VEC_W-1:0] vec;
    logic             lk_hit, set_en, sum_was;
    logic [IND_W-1:0] set_widx;
    logic [POS_W-1:0] set_vpos, set_spos;

    assign cfg_entry = '{vld: cfg_vld, fid: cfg_fid, isc: cfg_isc,
                         soff: cfg_soff, ind: cfg_ind};

    // Decode the MSI data word.
    assign lk_fid = ID_W'(wr_data >> ID_SHIFT);
    assign vec    = wr_data[VEC_W-1:0];

    msi_ai_ftab u_ftab (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .lk_fid(lk_fid), .lk_hit(lk_hit),
        .lk_entry(lk_entry)
    );

    // Map the vector and summary offset to LSB-based positions (bit n -> 63-n).
    assign set_en   = wr_valid && lk_hit;
    assign set_widx = lk_entry.ind + IND_W'(vec[VEC_W-1]);
    assign set_vpos = ~vec[POS_W-1:0];
    assign set_spos = ~lk_entry.soff;

    msi_ai_ind u_ind (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_widx(set_widx),
        .set_vpos(set_vpos), .set_spos(set_spos), .clr_en(clr_en),
        .clr_sel(clr_sel), .clr_vec_mask(clr_vec_mask),
        .clr_sum_mask(clr_sum_mask), .rd_sel(ind_sel), .rd_word(ind_word),
        .sum_q(sum_word), .sum_was(sum_was)
    );

    msi_ai_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fire(set_en && !sum_was),
        .isc(lk_entry.isc), .irq_valid(irq_valid), .irq_word(irq_word)
    );

    // Reads of the write window always return all ones.
    assign rd_data = rd_en ? 32'hFFFF_FFFF : 32'h0;

    assert_irq_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(wr_valid && lk_hit));

    assert_irq_sum_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(sum_word[~lk_entry.soff]));

    assert_miss_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !lk_hit && !clr_en) |=> ($stable(sum_word) && !irq_valid));
endmodule

// File: tb/msi_ai_conv_test.sv
`timescale 1ns/1ps
module msi_ai_conv_test;
    logic        clk = 0, rst_n = 0;
    logic        wr_valid = 0, rd_en = 0, cfg_we = 0, cfg_vld = 0, clr_en = 0;
    logic [31:0] wr_data = 0, cfg_fid = 0, rd_data, irq_word;
    logic [2:0]  cfg_idx = 0, cfg_isc = 0;
    logic [5:0]  cfg_soff = 0;
    logic [1:0]  cfg_ind = 0, clr_sel = 0, ind_sel = 0;
    logic [63:0] clr_vec_mask = 0, clr_sum_mask = 0, ind_word, sum_word;
    logic        irq_valid;
    int          checks = 0, errors = 0;

    // Bench model of table and indicator state
    logic        m_vld [8];
    logic [31:0] m_fid [8];
    logic [2:0]  m_isc [8];
    logic [5:0]  m_soff [8];
    logic [1:0]  m_ind [8];
    logic [63:0] m_vec [4];
    logic [63:0] m_sum;
    logic        m_irq;
    logic [31:0] m_word;

    always #2.5 clk = ~clk;

    msi_ai_conv uut (.*);

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_words(string req);
        for (int w = 0; w < 4; w++) begin
            ind_sel = 2'(w);
            #0.1;
            chk(req, ind_word, m_vec[w]);
        end
        chk(req, sum_word, m_sum);
    endtask

    task automatic cfg(int idx, logic v, int fid, int isc, int soff, int ind);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_vld = v; cfg_fid = 32'(fid);
        cfg_isc = 3'(isc); cfg_soff = 6'(soff); cfg_ind = 2'(ind);
        m_vld[idx] = v; m_fid[idx] = 32'(fid); m_isc[idx] = 3'(isc);
        m_soff[idx] = 6'(soff); m_ind[idx] = 2'(ind);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Expected-state update for one write, derived from the requirements.
    task automatic model(logic [31:0] d);
        logic [31:0] id = {11'b0, d[31:11]};
        logic [6:0]  v  = d[6:0];
        m_irq = 0; m_word = 0;
        for (int i = 0; i < 8; i++) begin
            if (m_vld[i] && m_fid[i] == id) begin
                m_vec[2'(m_ind[i] + 2'(v[6]))][63 - v[5:0]] = 1'b1;
                if (!m_sum[63 - m_soff[i]]) begin
                    m_irq = 1;
                    m_word = (32'(m_isc[i]) << 27) | 32'h8000_0000;
                end
                m_sum[63 - m_soff[i]] = 1'b1;
                break;
            end
        end
    endtask

    task automatic msi(string req, logic [31:0] d);
        @(negedge clk);
        wr_valid = 1; wr_data = d;
        model(d);
        @(negedge clk);
        wr_valid = 0;
        chk({req, " irq_valid"}, 64'(irq_valid), 64'(m_irq));
        if (m_irq) chk({req, " irq_word"}, 64'(irq_word), 64'(m_word));
    endtask

    function automatic logic [31:0] mk(int fid, int junk, int vec);
        return (32'(fid) << 11) | (32'(junk & 15) << 7) | 32'(vec & 127);
    endfunction

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
        for (int w = 0; w < 4; w++) m_vec[w] = 0;
        m_sum = 0;
        chk("R9 irq_valid", 64'(irq_valid), 0);
        chk_words("R9 words");
    endtask

    task automatic t_config();
        cfg(0, 1, 5, 3, 2, 1);
        cfg(1, 1, 7, 6, 2, 0);
        cfg(2, 1, 9, 0, 63, 3);
        cfg(3, 0, 12, 2, 20, 0);
        cfg(4, 1, 5, 1, 10, 2);
    endtask

    task automatic t_basic();
        msi("R10 R7 R5 first", mk(5, 0, 3));
        chk("R7 word", 64'(irq_word), 64'h9800_0000);
        chk_words("R3 R4 after first");
        msi("R5 shared summary", mk(7, 0, 0));
        chk_words("R3 shared");
        msi("R3 high vector", mk(5, 9, 70));
        chk_words("R3 high vector");
        msi("R1 R4 offset63", mk(9, 15, 127));
        chk("R1 word", 64'(irq_word), 64'h8000_0000);
        chk_words("R1 R3 R4 offset63");
        @(negedge clk);
        chk("R5 pulse one cycle", 64'(irq_valid), 0);
    endtask

    task automatic t_miss();
        msi("R2 invalid entry", mk(12, 0, 4));
        msi("R2 unknown id", mk(100, 0, 4));
        msi("R1 R2 id above bits", 32'h0000_0283 | (32'd1 << 31));
        chk_words("R2 unchanged");
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_en = 1; clr_sel = 0; clr_vec_mask = 64'h8000_0000_0000_0000;
        clr_sum_mask = '1;
        @(negedge clk);
        clr_en = 0;
        m_vec[0] &= ~64'h8000_0000_0000_0000;
        m_sum = 0;
        chk_words("R8 cleared");
        msi("R8 new irq", mk(7, 0, 1));
        chk("R8 word", 64'(irq_word), 64'hB000_0000);
        chk_words("R8 after write");
    endtask

    task automatic t_b2b();
        @(negedge clk);
        clr_en = 1; clr_sum_mask = '1; clr_vec_mask = 0;
        @(negedge clk);
        clr_en = 0; m_sum = 0;
        wr_valid = 1; wr_data = mk(5, 0, 8); model(wr_data);
        @(negedge clk);
        chk("R5 b2b first", 64'(irq_valid), 1);
        chk("R5 b2b first word", 64'(irq_word), 64'h9800_0000);
        wr_data = mk(9, 0, 9); model(wr_data);
        @(negedge clk);
        chk("R5 b2b second", 64'(irq_valid), 1);
        chk("R5 b2b second word", 64'(irq_word), 64'h8000_0000);
        wr_data = mk(5, 0, 11); model(wr_data);
        @(negedge clk);
        wr_valid = 0;
        chk("R5 b2b repeat suppressed", 64'(irq_valid), 0);
        chk_words("R3 R4 b2b");
    endtask

    task automatic t_read();
        @(negedge clk);
        rd_en = 1;
        #0.1 chk("R6 read", 64'(rd_data), 64'hFFFF_FFFF);
        @(negedge clk);
        rd_en = 0;
        #0.1 chk("R6 idle", 64'(rd_data), 0);
        chk_words("R6 no state change");
    endtask

    initial begin
        t_reset();
        t_config();
        t_basic();
        t_miss();
        t_clear();
        t_b2b();
        t_read();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule